// File: doc/BRIEF.md
# Two-Lane Interleaved Mersenne Twister Generator

This block is a 32-bit MT19937 pseudo-random generator that retires two state updates and delivers two tempered output words on every enabled clock cycle. The 624-word state lives in two register banks. The even bank holds words with even indices and has three combinational read ports. The odd bank holds words with odd indices and has two. A pair pointer `k` walks 0..311. In each enabled cycle, lane A rewrites word 2k from words 2k, 2k+1 and 2k+397. Lane B rewrites word 2k+1 from words 2k+1, 2k+2 and 2k+398. All indices are taken modulo 624. Word 2k+1 is read once and feeds both lanes.

The state is filled through a preload port before use, one word per cycle. Seeding arithmetic is left to the surrounding logic. When the two output words are read as a stream, lower index first, that stream is the same as the one a single-output MT19937 produces from the same state.

Top module: `mt_dual_gen`

## Requirements
- R1: While rst_ni is low and until the first enabled cycle after reset, valid_o is 0 and out0_o/out1_o are 0. The pair pointer starts at pair 0.
- R2: A cycle with load_i high and load_addr_i below 624 writes load_data_i into state word load_addr_i. Bit 0 of the address selects the odd bank and the remaining bits select the word in the bank. Later outputs reflect the written word.
- R3: A cycle with load_i high performs no generation, even when en_i is high. In the following cycle valid_o is 0, the outputs keep their values and the pair pointer does not move.
- R4: A cycle with en_i high and load_i low is a generate cycle. After the next rising edge valid_o is 1 and out0_o/out1_o carry the new pair. After any other cycle valid_o is 0.
- R5: out0_o carries the tempered word for index 2k and out1_o the tempered word for index 2k+1. Reading out0_o then out1_o for each valid cycle gives exactly the single-lane MT19937 stream. That stream uses the twist matrix 0x9908B0DF, bit 31 taken from the current word and bits 30..0 from the next word, and the feedback tap at offset 397.
- R6: After pair 311 the pointer wraps to pair 0. Later passes read words already rewritten in earlier passes, and the stream stays identical to the reference across pass boundaries.
- R7: A cycle with en_i and load_i both low leaves the state and the pointer unchanged and holds out0_o/out1_o. The next generate cycle continues the stream with no gap.
- R8: With the state preloaded from the standard initialisation of seed 5489, the first generate cycle yields out0_o = 0xD091BB5C and out1_o = 0x22AE9EF6. This checks the tempering shifts 11, 7, 15 and 18 and the masks 0x9D2C5680 and 0xEFC60000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Request one pair of outputs this cycle |
| load_i | input | 1 | Write one state word this cycle (has priority over en_i) |
| load_addr_i | input | 10 | State word index, 0..623 |
| load_data_i | input | 32 | State word value to write |
| out0_o | output | 32 | Tempered word for the lower index of the pair |
| out1_o | output | 32 | Tempered word for the higher index of the pair |
| valid_o | output | 1 | out0_o/out1_o were updated by the previous cycle |

## Verification
Each result is due one rising edge after the cycle that asked for it. A generate cycle updates the outputs and sets valid_o at the next edge. A load or idle cycle clears valid_o at that same edge and leaves the outputs held. State written by a load becomes visible to generate cycles that start after that edge. The bench changes inputs on the falling edge, lets one rising edge pass and samples 1 ns later. It compares against a sequential software model of the generator, which it advances by two words per generate cycle and updates on each load.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam word_t TWIST_XOR  = 32'h9908_B0DF;
  localparam word_t HI_MASK    = 32'h8000_0000;
  localparam word_t LO_MASK    = 32'h7FFF_FFFF;
  localparam word_t TMP_MASK_B = 32'h9D2C_5680;
  localparam word_t TMP_MASK_C = 32'hEFC6_0000;
  localparam int    TMP_SH_U   = 11;
  localparam int    TMP_SH_S   = 7;
  localparam int    TMP_SH_T   = 15;
  localparam int    TMP_SH_L   = 18;
endpackage

// File: rtl/mt_bank.sv
module mt_bank #(
  parameter int DEPTH = 312,
  parameter int NRD   = 2,
  parameter int W     = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [NRD*AW-1:0] raddr_i,
  output logic [NRD*W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g*W +: W] = mem[raddr_i[g*AW +: AW]];
  end

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/mt_lane.sv
module mt_lane
  import mt_pkg::*;
(
  input  word_t cur_i,
  input  word_t nxt_i,
  input  word_t tap_i,
  output word_t next_o,
  output word_t rand_o
);
  word_t mix, t1, t2, t3;

  always_comb begin
    mix    = (cur_i & HI_MASK) | (nxt_i & LO_MASK);
    next_o = tap_i ^ (mix >> 1) ^ (mix[0] ? TWIST_XOR : '0);
    t1     = next_o ^ (next_o >> TMP_SH_U);
    t2     = t1 ^ ((t1 << TMP_SH_S) & TMP_MASK_B);
    t3     = t2 ^ ((t2 << TMP_SH_T) & TMP_MASK_C);
    rand_o = t3 ^ (t3 >> TMP_SH_L);
  end
endmodule

// File: rtl/mt_pair_ctrl.sv
module mt_pair_ctrl #(
  parameter int PAIRS    = 312,
  parameter int EVEN_TAP = 199,
  parameter int ODD_TAP  = 198,
  parameter int AW       = $clog2(PAIRS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] pair_o,
  output logic [AW-1:0] pair_nxt_o,
  output logic [AW-1:0] even_tap_o,
  output logic [AW-1:0] odd_tap_o
);
  localparam logic [AW-1:0] LAST = AW'(PAIRS - 1);

  logic [AW-1:0] pair_q;

  function automatic logic [AW-1:0] wrap_add(logic [AW-1:0] a, int unsigned off);
    logic [AW:0] s;
    s = {1'b0, a} + (AW+1)'(off);
    if (s >= (AW+1)'(PAIRS)) s = s - (AW+1)'(PAIRS);
    return s[AW-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pair_q <= '0;
    else if (adv_i) pair_q <= (pair_q == LAST) ? '0 : pair_q + AW'(1);
  end

  assign pair_o     = pair_q;
  assign pair_nxt_o = wrap_add(pair_q, 1);
  assign even_tap_o = wrap_add(pair_q, EVEN_TAP);
  assign odd_tap_o  = wrap_add(pair_q, ODD_TAP);

  a_r6_pair_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && pair_q == LAST) |=> pair_q == '0);
  a_r6_pair_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && pair_q != LAST) |=> pair_q == $past(pair_q) + AW'(1));
  a_r7_pair_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(pair_q));
endmodule

// File: rtl/mt_dual_gen.sv
module mt_dual_gen
  import mt_pkg::*;
#(
  parameter int STATE_N = 624,
  parameter int TAP_M   = 397,
  parameter int IW      = $clog2(STATE_N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [IW-1:0] load_addr_i,
  input  logic [31:0]   load_data_i,
  output logic [31:0]   out0_o,
  output logic [31:0]   out1_o,
  output logic          valid_o
);
  localparam int PAIRS    = STATE_N / 2;
  localparam int AW       = $clog2(PAIRS);
  localparam int EVEN_TAP = (TAP_M + 1) / 2;  // pair offset of word 2k+M+1
  localparam int ODD_TAP  = (TAP_M - 1) / 2;  // pair offset of word 2k+M

  logic          fire, load_ok;
  logic [AW-1:0] pair, pair_nxt, even_tap, odd_tap, load_row;
  logic [3*W_BITS()-1:0] ev_rd;
  logic [2*W_BITS()-1:0] od_rd;
  logic          ev_we, od_we;
  logic [AW-1:0] ev_wa, od_wa;
  word_t         ev_wd, od_wd;
  word_t         a_next, a_rand, b_next, b_rand;
  word_t         out0_q, out1_q;
  logic          valid_q;

  function automatic int W_BITS();
    return WORD_W;
  endfunction

  assign fire     = en_i && !load_i;
  assign load_ok  = load_i && (load_addr_i < IW'(STATE_N));
  assign load_row = AW'(load_addr_i >> 1);

  mt_pair_ctrl #(
    .PAIRS(PAIRS), .EVEN_TAP(EVEN_TAP), .ODD_TAP(ODD_TAP), .AW(AW)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(fire),
    .pair_o(pair), .pair_nxt_o(pair_nxt),
    .even_tap_o(even_tap), .odd_tap_o(odd_tap)
  );

  // Write port muxing: generation owns both banks, otherwise a load hits one
  always_comb begin
    ev_we = 1'b0; ev_wa = pair; ev_wd = a_next;
    od_we = 1'b0; od_wa = pair; od_wd = b_next;
    if (fire) begin
      ev_we = 1'b1;
      od_we = 1'b1;
    end else if (load_ok) begin
      if (load_addr_i[0]) begin
        od_we = 1'b1; od_wa = load_row; od_wd = load_data_i;
      end else begin
        ev_we = 1'b1; ev_wa = load_row; ev_wd = load_data_i;
      end
    end
  end

  // even reads: 2k, 2k+2, 2k+M+1 ; odd reads: 2k+1 (shared), 2k+M
  mt_bank #(.DEPTH(PAIRS), .NRD(3), .W(WORD_W), .AW(AW)) u_even (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ev_we), .waddr_i(ev_wa), .wdata_i(ev_wd),
    .raddr_i({even_tap, pair_nxt, pair}), .rdata_o(ev_rd)
  );

  mt_bank #(.DEPTH(PAIRS), .NRD(2), .W(WORD_W), .AW(AW)) u_odd (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(od_we), .waddr_i(od_wa), .wdata_i(od_wd),
    .raddr_i({odd_tap, pair}), .rdata_o(od_rd)
  );

  mt_lane u_lane_a (
    .cur_i(ev_rd[0 +: WORD_W]), .nxt_i(od_rd[0 +: WORD_W]), .tap_i(od_rd[WORD_W +: WORD_W]),
    .next_o(a_next), .rand_o(a_rand)
  );

  mt_lane u_lane_b (
    .cur_i(od_rd[0 +: WORD_W]), .nxt_i(ev_rd[WORD_W +: WORD_W]), .tap_i(ev_rd[2*WORD_W +: WORD_W]),
    .next_o(b_next), .rand_o(b_rand)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out0_q  <= '0;
      out1_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire;
      if (fire) begin
        out0_q <= a_rand;
        out1_q <= b_rand;
      end
    end
  end

  assign out0_o  = out0_q;
  assign out1_o  = out1_q;
  assign valid_o = valid_q;

  a_r4_valid_after_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> valid_o);
  a_r4_no_valid_without_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && !load_i) |=> !valid_o);
  a_r3_load_blocks_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!valid_o && $stable(out0_o) && $stable(out1_o)));
  a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> ($stable(out0_o) && $stable(out1_o)));
endmodule

// File: tb/mt_dual_gen_bench.sv
module mt_dual_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        load_i = 1'b0;
  logic [9:0]  load_addr_i = '0;
  logic [31:0] load_data_i = '0;
  logic [31:0] out0_o, out1_o;
  logic        valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] ref_mt [624];
  int          ref_idx = 0;
  int          ref_pass = 0;
  logic [31:0] e0 = '0, e1 = '0;

  always #5 clk_i = ~clk_i;

  mt_dual_gen u_mt_dual_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .load_i(load_i),
    .load_addr_i(load_addr_i), .load_data_i(load_data_i),
    .out0_o(out0_o), .out1_o(out1_o), .valid_o(valid_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // sequential single-lane model
  task automatic ref_gen(output logic [31:0] r);
    logic [31:0] y, v;
    y = (ref_mt[ref_idx] & 32'h8000_0000) | (ref_mt[(ref_idx + 1) % 624] & 32'h7FFF_FFFF);
    v = ref_mt[(ref_idx + 397) % 624] ^ (y >> 1) ^ (y[0] ? 32'h9908_B0DF : 32'h0);
    ref_mt[ref_idx] = v;
    ref_idx = ref_idx + 1;
    if (ref_idx == 624) begin
      ref_idx = 0;
      ref_pass++;
    end
    v = v ^ (v >> 11);
    v = v ^ ((v << 7) & 32'h9D2C_5680);
    v = v ^ ((v << 15) & 32'hEFC6_0000);
    r = v ^ (v >> 18);
  endtask

  task automatic step(bit en, bit ld, logic [9:0] a, logic [31:0] d);
    bit ev;
    string tag;
    logic [31:0] w0, w1;
    @(negedge clk_i);
    en_i = en; load_i = ld; load_addr_i = a; load_data_i = d;
    if (ld) begin
      ref_mt[a] = d; ev = 0; tag = "R3";
    end else if (en) begin
      tag = (ref_pass > 0) ? "R6" : "R5";
      ref_gen(w0); ref_gen(w1);
      e0 = w0; e1 = w1; ev = 1;
    end else begin
      ev = 0; tag = "R7";
    end
    @(posedge clk_i); #1;
    chk({tag, "/R4 valid"}, {31'b0, valid_o}, {31'b0, ev});
    chk({tag, " out0"}, out0_o, e0);
    chk({tag, " out1"}, out1_o, e1);
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_state [624];
    void'($urandom(32'd20240917));
    seed_state[0] = 32'd5489;
    for (int i = 1; i < 624; i++)
      seed_state[i] = 32'd1812433253 * (seed_state[i-1] ^ (seed_state[i-1] >> 30)) + 32'(i);

    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 valid in reset", {31'b0, valid_o}, 32'd0);
    chk("R1 out0 in reset", out0_o, 32'd0);
    chk("R1 out1 in reset", out1_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 valid after reset", {31'b0, valid_o}, 32'd0);

    // R2: preload the full state, odd and even words alike
    for (int i = 0; i < 624; i++) step(1'b0, 1'b1, 10'(i), seed_state[i]);

    // R8: known first outputs of seed 5489, starting at pair 0 (R1)
    step(1'b1, 1'b0, '0, '0);
    chk("R8 first out0", out0_o, 32'hD091_BB5C);
    chk("R8 first out1", out1_o, 32'h22AE_9EF6);

    // R7: idle gap then continuation
    repeat (4) step(1'b0, 1'b0, '0, '0);
    repeat (3) step(1'b1, 1'b0, '0, '0);

    // R3: load and enable together, load wins
    step(1'b1, 1'b1, 10'd5, 32'hDEAD_BEEF);
    step(1'b1, 1'b0, '0, '0);

    // R6: run straight through two pass boundaries
    repeat (650) step(1'b1, 1'b0, '0, '0);

    // mixed random traffic
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom % 16;
      if (r < 10)       step(1'b1, 1'b0, '0, '0);
      else if (r < 12)  step(1'b1, 1'b1, 10'($urandom % 624), $urandom);
      else if (r < 13)  step(1'b0, 1'b1, 10'($urandom % 624), $urandom);
      else              step(1'b0, 1'b0, '0, '0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule